// File: doc/BRIEF.md
# Synchronized Clock Stop Gate

This block switches one bank of output clocks on and off from an active-low stop request. The request may change at any time and is not related to the bank's clock. The block passes the request through a synchronizer clocked by the bank's source clock. It then updates the gate enable only while that clock is low, so the bank output can never show a shortened pulse. A stopped bank always rests at logic 0. A restarted bank always begins with a high phase of full width.

Each instance drives one bank of identical lanes. Several instances can share a source clock and control independent banks, such as a processor bank and a peripheral bus bank. Clocks that are not routed through an instance keep running untouched. A status output shows when the bank has actually come to rest low.

Top module: `clk_stop_gate`

## Requirements
- R1: Driving `stop_n` to 0 stops the bank and driving it to 1 restarts it; a level must be held for at least SYNC_STAGES+2 source cycles to take effect.
- R2: After `stop_n` falls between source clock edges, exactly SYNC_STAGES further rising edges (default 2) reach the bank outputs, and no rising edge follows them while the request stays low.
- R3: While `bank_stopped` is 1, every lane of `gated_clk` is 0, including during the source clock's high phase.
- R4: Every high phase of a bank output lasts exactly half a source period, and every low phase lasts half a source period plus a whole number of source periods.
- R5: After `stop_n` rises between edges, the first bank rising edge is the (SYNC_STAGES+1)th source rising edge, so SYNC_STAGES+2 source edges after release have given exactly 2 output rising edges.
- R6: `bank_stopped` becomes 1 on the first source rising edge at which the output stays low, and becomes 0 on the first source rising edge that is passed to the output again.
- R7: While `rst_n` is 0 (sampled on the clock), the outputs are 0 and `bank_stopped` is 1. After release with `stop_n` high, the bank starts the same way as in R5.
- R8: All lanes of `gated_clk` carry the same value at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Free-running source clock of the bank |
| rst_n | input | 1 | Synchronous reset, active low |
| stop_n | input | 1 | Asynchronous stop request, 0 = stop, 1 = run |
| gated_clk | output | LANES | Gated bank clock lanes |
| bank_stopped | output | 1 | 1 while the bank output is parked low |

## Verification
On every cycle the embedded assertions check three things: the output stays low whenever the status flag reports a parked bank, the lanes agree, and the status flag follows a change of the synchronized request by exactly one edge. Only the bench scenarios can show the end-to-end properties. These are the number of output edges that slip through after an asynchronous request, the delay of the first restored edge, and the absence of any runt pulse. The bench shows them by timing every high and low phase of the output against randomly placed request changes.

// File: rtl/clk_stop_gate_pkg.sv
`timescale 1ps/1ps
// Package: shared defaults for the clock stop gate.
// Assumes: users override the parameters per instance where needed.
package clk_stop_gate_pkg;
    localparam int DEF_SYNC_STAGES = 2;
    localparam int DEF_LANES       = 4;
    localparam int MIN_SYNC_STAGES = 2;

    // Clamp a requested synchronizer depth to a safe minimum.
    function automatic int safe_stages(input int req);
        return (req < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : req;
    endfunction
endpackage

// File: rtl/stop_req_sync.sv
`timescale 1ps/1ps
// Module: stop_req_sync
// Brings the asynchronous stop request into the source clock domain.
// Assumes: STAGES >= 2. Reset forces "stop", so that a bank never starts
// before its request has been seen settled for STAGES edges.
module stop_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_n_async,
    output logic run_req
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain_q;

    // Shift the raw request through the synchronizer flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[TOP-1:0], stop_n_async};
        end
    end

    assign run_req = chain_q[TOP];
endmodule

// File: rtl/gate_enable_ctrl.sv
`timescale 1ps/1ps
// Module: gate_enable_ctrl
// Holds the gate enable, which changes only on the falling source edge, so
// the AND gate downstream sees it change only while the clock is low. It
// also produces the parked status, updated on the rising edge.
// Assumes: run_req is already synchronous to clk.
module gate_enable_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic run_req,
    output logic gate_en,
    output logic parked
);
    logic en_q;
    logic parked_q;

    // Load the enable while the clock is low, so no output edge is cut.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= run_req;
        end
    end

    // Report parked once a rising edge has passed with the gate closed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            parked_q <= 1'b1;
        end else begin
            parked_q <= ~en_q;
        end
    end

    assign gate_en = en_q;
    assign parked  = parked_q;

    AST_STOP_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_req) |=> parked); // R6
    AST_START_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_req) |=> !parked); // R6
endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ps/1ps
// Module: clk_stop_gate (top)
// Gates one bank of LANES identical clock lanes under an asynchronous
// active-low stop request. Parks low, restarts with a full high phase.
// Assumes: src_clk is free running and has a duty cycle near 50 %.
module clk_stop_gate
    import clk_stop_gate_pkg::*;
#(
    parameter int SYNC_STAGES = DEF_SYNC_STAGES,
    parameter int LANES       = DEF_LANES
) (
    input  logic             src_clk,
    input  logic             rst_n,
    input  logic             stop_n,
    output logic [LANES-1:0] gated_clk,
    output logic             bank_stopped
);
    localparam int STAGES_USED = safe_stages(SYNC_STAGES);

    logic run_req;
    logic gate_en;

    stop_req_sync #(.STAGES(STAGES_USED)) sync_i (
        .clk          (src_clk),
        .rst_n        (rst_n),
        .stop_n_async (stop_n),
        .run_req      (run_req)
    );

    gate_enable_ctrl ctrl_i (
        .clk     (src_clk),
        .rst_n   (rst_n),
        .run_req (run_req),
        .gate_en (gate_en),
        .parked  (bank_stopped)
    );

    // One AND gate per lane; the enable only moves while src_clk is low.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign gated_clk[g] = src_clk & gate_en;
    end

    AST_PARKED_LOW: assert property (@(negedge src_clk) disable iff (!rst_n)
        bank_stopped |-> (gated_clk == '0)); // R3
    AST_LANES_AGREE: assert property (@(negedge src_clk) disable iff (!rst_n)
        (gated_clk == '0) || (gated_clk == '1)); // R8
    AST_RUN_HIGH_PHASE: assert property (@(negedge src_clk) disable iff (!rst_n)
        !bank_stopped |-> (gated_clk == '1)); // R4
endmodule

// File: tb/clk_stop_gate_tb_top.sv
`timescale 1ps/1ps
// Bench: random and directed stop/restart sequences with edge counting
// and pulse width measurement on lane 0.
module clk_stop_gate_tb_top;
    localparam int  S     = 2;
    localparam int  L     = 4;
    localparam longint HALF = 4000;
    localparam longint PER  = 8000;

    logic         src_clk = 1'b0;
    logic         rst_n   = 1'b0;
    logic         stop_n  = 1'b1;
    logic [L-1:0] gated_clk;
    logic         bank_stopped;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    int rise_cnt = 0;
    longint t_rise = -1;
    longint t_fall = -1;

    clk_stop_gate #(.SYNC_STAGES(S), .LANES(L)) dut_i (
        .src_clk      (src_clk),
        .rst_n        (rst_n),
        .stop_n       (stop_n),
        .gated_clk    (gated_clk),
        .bank_stopped (bank_stopped)
    );

    always #(HALF) src_clk = ~src_clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected output rising edges within S+2 source edges after a change.
    function automatic int exp_rises(input bit stopping);
        return stopping ? S : 2;
    endfunction

    function automatic bit low_width_ok(input longint w);
        return (w >= HALF) && (((w - HALF) % PER) == 0);
    endfunction

    // Pulse width monitor, R4: full high phases, low phases on the grid.
    always @(posedge gated_clk[0]) begin
        rise_cnt++;
        if (rst_n && t_fall >= 0)
            chk(low_width_ok($time - t_fall), "R4 low phase", $time - t_fall, HALF);
        t_rise = $time;
    end
    always @(negedge gated_clk[0]) begin
        if (rst_n && t_rise >= 0)
            chk(($time - t_rise) == HALF, "R4 high phase", $time - t_rise, HALF);
        t_fall = $time;
    end

    // Drive a new request level mid-cycle and check the response.
    task automatic apply(input bit level, input int offs);
        @(negedge src_clk);
        #(offs);
        stop_n   = level;
        rise_cnt = 0;
        repeat (S + 2) @(posedge src_clk);
        #1000;
        if (!level) begin
            chk(rise_cnt == exp_rises(1), "R2 edges after stop", rise_cnt, exp_rises(1));
            chk(gated_clk == '0, "R3 parked low in high phase", gated_clk, 0);
            chk(bank_stopped == 1'b1, "R6 stopped flag set", bank_stopped, 1);
        end else begin
            chk(rise_cnt == exp_rises(0), "R5 first restored edge", rise_cnt, exp_rises(0));
            chk(gated_clk == '1, "R1 bank running", gated_clk, {L{1'b1}});
            chk(bank_stopped == 1'b0, "R6 stopped flag clear", bank_stopped, 0);
        end
        chk((gated_clk == '0) || (gated_clk == '1), "R8 lanes agree", gated_clk, 0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge src_clk);
        #1000;
        chk(gated_clk == '0, "R7 reset output low", gated_clk, 0);
        chk(bank_stopped == 1'b1, "R7 reset stopped flag", bank_stopped, 1);
        @(negedge src_clk);
        #1000;
        rst_n    = 1'b1;
        rise_cnt = 0;
        repeat (S + 2) @(posedge src_clk);
        #1000;
        chk(rise_cnt == 2, "R7 start after reset", rise_cnt, 2);
        chk(bank_stopped == 1'b0, "R7 flag clear after start", bank_stopped, 0);

        // Directed: stop just after a falling edge and just before a rising edge.
        apply(1'b0, 100);
        repeat (5) @(posedge src_clk);
        apply(1'b1, 3900);
        apply(1'b0, 3900);
        apply(1'b1, 100);

        // Random: alternate levels with random placement and hold times.
        for (int i = 0; i < 40; i++) begin
            apply(i[0] ? 1'b1 : 1'b0, 100 + int'($urandom % 3800));
            repeat ($urandom % 8) @(posedge src_clk);
            if (!i[0]) begin
                #1000;
                chk(gated_clk == '0 && bank_stopped, "R3 stays parked", gated_clk, 0);
            end
        end
        repeat (4) @(posedge src_clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PER * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule